// File: doc/BRIEF.md
# Multiplexed-Bus to Asynchronous SRAM Glue

This block joins a bus master with a time-shared address/data byte to an external 8 KB asynchronous SRAM. In the first half of each bus cycle the shared byte carries the low address, and the master marks it with an address strobe. In the second half the same byte carries data. The glue holds the low address byte captured under the strobe. It joins that byte with the low five bits of the master's high address port to form a 13-bit memory address.

The three top bits of the high address split the 64 KB space into eight 8 KB windows. The memory answers only in window 2 (`0x4000`-`0x5FFF`). All memory strobes are gated by the bus clock E, so the memory is driven only in the second half of the cycle. On a write the glue forwards the master's byte to the memory pins. On a read it returns the memory's byte to the master. A separate drive-enable is given for each direction, so the pad ring can build the tri-state pins.

Top module: `ext_sram_glue`

## Requirements
- R1: While `bus_as` is high, `mem_addr[7:0]` equals `bus_ad_i` in the same cycle (transparent capture).
- R2: While `bus_as` is low, `mem_addr[7:0]` holds the `bus_ad_i` value seen at the last rising `clk` edge at which `bus_as` was high. Reset (`rst_n` low) clears this held byte to 0 at once.
- R3: `mem_addr[12:8]` equals `bus_a_hi[4:0]` at all times.
- R4: `mem_cs_n` is low exactly when `bus_e` is 1 and `bus_a_hi[7:5]` equals 3'b010; otherwise it is high.
- R5: `mem_cs` (the active-high chip select) is always 1.
- R6: `mem_we_n` is low exactly when the memory is selected (R4) and `bus_rw` is 0 (write).
- R7: `mem_oe_n` is low exactly when the memory is selected (R4) and `bus_rw` is 1 (read).
- R8: `mem_dq_oe` is 1 exactly during a selected write, and then `mem_dq_o` equals `bus_ad_i`.
- R9: `bus_ad_oe` is 1 exactly during a selected read, and then `bus_ad_o` equals `mem_dq_i`.
- R10: When `bus_a_hi[7:5]` is not 3'b010, `mem_cs_n`, `mem_we_n` and `mem_oe_n` are all high, and both `mem_dq_oe` and `bus_ad_oe` are 0, whatever `bus_e` and `bus_rw` are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, faster than the bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_e | input | 1 | Bus clock E; high in the data half of a cycle |
| bus_rw | input | 1 | 1 = read, 0 = write |
| bus_as | input | 1 | Address strobe; high while the shared byte is a low address |
| bus_a_hi | input | 8 | High address byte A15..A8 |
| bus_ad_i | input | 8 | Shared address/data byte from the master |
| bus_ad_o | output | 8 | Read data returned to the master |
| bus_ad_oe | output | 1 | Drive enable for `bus_ad_o` |
| mem_addr | output | 13 | SRAM address |
| mem_cs_n | output | 1 | Active-low chip select |
| mem_cs | output | 1 | Active-high chip select |
| mem_we_n | output | 1 | Active-low write enable |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_dq_o | output | 8 | Write data towards the SRAM |
| mem_dq_oe | output | 1 | Drive enable for `mem_dq_o` |
| mem_dq_i | input | 8 | Read data from the SRAM |

## Verification
The strobes, the data paths, the high address bits and the transparent low byte are all combinational. They are due in the same cycle as the input that moves them. The bench drives at a falling edge and samples one nanosecond later, before the next rising edge. The held low byte changes only at a rising edge with the strobe high. So the hold checks sample after the strobe has dropped, a full rising edge after the capture, and while the shared byte carries a different value. Reset clears the held byte at once, and it is checked in the same half cycle as the reset.

// File: rtl/ext_sram_glue_pkg.sv
package ext_sram_glue_pkg;
  localparam int BUS_AW = 16;
  localparam int BUS_DW = 8;
  localparam int MEM_AW = 13;

  typedef struct packed {
    logic cs_n;
    logic we_n;
    logic oe_n;
    logic wr_drv;
    logic rd_drv;
  } strobe_t;
endpackage

// File: rtl/ext_sram_glue_alatch.sv
module ext_sram_glue_alatch #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         le_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] held_q;
  logic [W-1:0] held_d;

  always_comb begin
    held_d = held_q;
    if (le_i) held_d = d_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) held_q <= '0;
    else        held_q <= held_d;
  end

  assign q_o = le_i ? d_i : held_q;

  // R2: with the strobe low across an edge, the held byte must not move
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!le_i && $past(!le_i)) |-> $stable(q_o));
endmodule

// File: rtl/ext_sram_glue_decode.sv
module ext_sram_glue_decode #(
  parameter int AW     = 16,
  parameter int MEM_AW = 13,
  parameter int WINDOW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_e_i,
  input  logic [AW-1:0] addr_i,
  output logic          sel_o
);
  localparam int SEL_W = AW - MEM_AW;
  localparam logic [SEL_W-1:0] WIN_CODE = SEL_W'(WINDOW);

  logic hit;
  assign hit   = (addr_i[AW-1 -: SEL_W] == WIN_CODE);
  assign sel_o = hit && bus_e_i;

  // R4: a select is never seen in the address half of the cycle
  p_sel_needs_e_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sel_o |-> bus_e_i);
endmodule

// File: rtl/ext_sram_glue_strobe.sv
module ext_sram_glue_strobe
  import ext_sram_glue_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    sel_i,
  input  logic    rw_i,
  output strobe_t stb_o
);
  always_comb begin
    stb_o        = '{cs_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, wr_drv: 1'b0, rd_drv: 1'b0};
    if (sel_i) begin
      stb_o.cs_n = 1'b0;
      if (rw_i) begin
        stb_o.oe_n   = 1'b0;
        stb_o.rd_drv = 1'b1;
      end else begin
        stb_o.we_n   = 1'b0;
        stb_o.wr_drv = 1'b1;
      end
    end
  end

  // R6: a write strobe only appears under chip select
  p_we_needs_cs_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !stb_o.we_n |-> !stb_o.cs_n);
  // R7: read and write strobes never overlap
  p_we_oe_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({~stb_o.we_n, ~stb_o.oe_n}));
  // R9: both sides never drive at the same time
  p_drive_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(stb_o.wr_drv && stb_o.rd_drv));
endmodule

// File: rtl/ext_sram_glue.sv
module ext_sram_glue
  import ext_sram_glue_pkg::*;
#(
  parameter int AW     = BUS_AW,
  parameter int DW     = BUS_DW,
  parameter int MAW    = MEM_AW,
  parameter int WINDOW = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bus_e,
  input  logic           bus_rw,
  input  logic           bus_as,
  input  logic [DW-1:0]  bus_a_hi,
  input  logic [DW-1:0]  bus_ad_i,
  output logic [DW-1:0]  bus_ad_o,
  output logic           bus_ad_oe,
  output logic [MAW-1:0] mem_addr,
  output logic           mem_cs_n,
  output logic           mem_cs,
  output logic           mem_we_n,
  output logic           mem_oe_n,
  output logic [DW-1:0]  mem_dq_o,
  output logic           mem_dq_oe,
  input  logic [DW-1:0]  mem_dq_i
);
  localparam int HI_KEEP = MAW - DW;
  localparam int SEL_W   = AW - MAW;

  logic    rst_meta_q, rst_sync_q;
  logic    rst_meta_d, rst_sync_d;
  logic [DW-1:0] lo_addr;
  logic    sel;
  strobe_t stb;

  // reset: asserted at once, released after two clock edges
  always_comb begin
    rst_meta_d = 1'b1;
    rst_sync_d = rst_meta_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= rst_meta_d;
      rst_sync_q <= rst_sync_d;
    end
  end

  ext_sram_glue_alatch #(.W(DW)) i_alatch (
    .clk   (clk),
    .rst_n (rst_sync_q),
    .le_i  (bus_as),
    .d_i   (bus_ad_i),
    .q_o   (lo_addr)
  );

  ext_sram_glue_decode #(.AW(AW), .MEM_AW(MAW), .WINDOW(WINDOW)) i_decode (
    .clk     (clk),
    .rst_n   (rst_sync_q),
    .bus_e_i (bus_e),
    .addr_i  ({bus_a_hi, lo_addr}),
    .sel_o   (sel)
  );

  ext_sram_glue_strobe i_strobe (
    .clk   (clk),
    .rst_n (rst_sync_q),
    .sel_i (sel),
    .rw_i  (bus_rw),
    .stb_o (stb)
  );

  assign mem_addr  = {bus_a_hi[HI_KEEP-1:0], lo_addr};
  assign mem_cs_n  = stb.cs_n;
  assign mem_cs    = 1'b1;
  assign mem_we_n  = stb.we_n;
  assign mem_oe_n  = stb.oe_n;
  assign mem_dq_o  = bus_ad_i;
  assign mem_dq_oe = stb.wr_drv;
  assign bus_ad_o  = mem_dq_i;
  assign bus_ad_oe = stb.rd_drv;

  // R1: the memory sees the shared byte while the strobe is high
  p_transparent_r1: assert property (@(posedge clk) disable iff (!rst_sync_q)
    bus_as |-> (mem_addr[DW-1:0] == bus_ad_i));
  // R10: an address outside the window leaves the memory untouched
  p_quiet_r10: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (bus_a_hi[DW-1 -: SEL_W] != SEL_W'(WINDOW)) |->
      (mem_cs_n && mem_we_n && mem_oe_n && !mem_dq_oe && !bus_ad_oe));
endmodule

// File: tb/test_ext_sram_glue.sv
module test_ext_sram_glue;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_e, bus_rw, bus_as;
  logic [7:0]  bus_a_hi, bus_ad_i, bus_ad_o, mem_dq_o, mem_dq_i;
  logic        bus_ad_oe, mem_cs_n, mem_cs, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [12:0] mem_addr;

  int n_chk = 0;
  int n_err = 0;
  int cyc   = 0;

  always #2 clk = ~clk;

  ext_sram_glue i_ext_sram_glue (
    .clk(clk), .rst_n(rst_n), .bus_e(bus_e), .bus_rw(bus_rw), .bus_as(bus_as),
    .bus_a_hi(bus_a_hi), .bus_ad_i(bus_ad_i), .bus_ad_o(bus_ad_o),
    .bus_ad_oe(bus_ad_oe), .mem_addr(mem_addr), .mem_cs_n(mem_cs_n),
    .mem_cs(mem_cs), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
  );

  // {hi, lo, rw, data, expected {cs_n, we_n, oe_n, dq_oe, ad_oe}}
  localparam logic [29:0] VEC [8] = '{
    {8'h40, 8'h00, 1'b0, 8'hA5, 5'b00110},
    {8'h5F, 8'hFF, 1'b1, 8'h3C, 5'b01001},
    {8'h3F, 8'hFF, 1'b1, 8'h5A, 5'b11100},
    {8'h60, 8'h00, 1'b0, 8'hC3, 5'b11100},
    {8'h00, 8'h12, 1'b0, 8'h77, 5'b11100},
    {8'hE0, 8'h34, 1'b1, 8'h88, 5'b11100},
    {8'h4A, 8'h5C, 1'b0, 8'h81, 5'b00110},
    {8'h52, 8'h01, 1'b1, 8'h7E, 5'b01001}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [4:0] strobes();
    return {mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe, bus_ad_oe};
  endfunction

  task automatic bus_cycle(input logic [7:0] hi, input logic [7:0] lo,
                           input logic rw, input logic [7:0] dat, input logic [4:0] ex);
    @(negedge clk);
    bus_a_hi = hi; bus_rw = rw; bus_e = 1'b0; bus_as = 1'b1;
    bus_ad_i = lo; mem_dq_i = 8'h00;
    #1;
    chk("R1 transparent low byte", 32'(mem_addr[7:0]), 32'(lo));
    chk("R4 no strobe while E low", 32'(strobes()), 32'(5'b11100));
    @(negedge clk);
    bus_as = 1'b0; bus_e = 1'b1;
    if (rw) begin bus_ad_i = ~lo; mem_dq_i = dat; end
    else    begin bus_ad_i = dat; end
    #1;
    chk("R2 held low byte", 32'(mem_addr[7:0]), 32'(lo));
    chk("R3 high address bits", 32'(mem_addr[12:8]), 32'(hi[4:0]));
    chk("R4 R6 R7 R10 strobes", 32'(strobes()), 32'(ex));
    chk("R5 high chip select", 32'(mem_cs), 32'(1'b1));
    if (ex[1]) chk("R8 write data", 32'(mem_dq_o), 32'(dat));
    if (ex[0]) chk("R9 read data", 32'(bus_ad_o), 32'(dat));
    @(negedge clk);
    bus_e = 1'b0;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000) begin
        n_err++; n_chk++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
      end
    end
  end

  initial begin
    rst_n = 1'b0; bus_e = 1'b0; bus_rw = 1'b1; bus_as = 1'b0;
    bus_a_hi = 8'h40; bus_ad_i = 8'hEE; mem_dq_i = 8'h00;
    repeat (3) @(negedge clk);
    #1;
    chk("R2 reset clears held byte", 32'(mem_addr[7:0]), 32'(0));
    chk("R4 reset idle strobes", 32'(strobes()), 32'(5'b11100));
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);

    for (int i = 0; i < 8; i++) begin
      logic [29:0] v;
      v = VEC[i];
      bus_cycle(v[29:22], v[21:14], v[13], v[12:5], v[4:0]);
    end

    // R1: low byte follows the bus within one strobe-high interval
    @(negedge clk);
    bus_a_hi = 8'h41; bus_as = 1'b1; bus_ad_i = 8'h11;
    #1; chk("R1 follow first", 32'(mem_addr[7:0]), 32'(8'h11));
    bus_ad_i = 8'h99;
    #1; chk("R1 follow second", 32'(mem_addr[7:0]), 32'(8'h99));

    // R2: hold across several cycles while the shared byte changes
    @(negedge clk); bus_as = 1'b0;
    for (int k = 0; k < 3; k++) begin
      bus_ad_i = 8'(8'h20 + k);
      @(negedge clk); #1;
      chk("R2 hold over cycles", 32'(mem_addr[7:0]), 32'(8'h99));
    end

    // R10: E high, write, outside the window
    bus_a_hi = 8'h80; bus_rw = 1'b0; bus_e = 1'b1;
    #1; chk("R10 out of window write", 32'(strobes()), 32'(5'b11100));
    bus_rw = 1'b1;
    #1; chk("R10 out of window read", 32'(strobes()), 32'(5'b11100));
    bus_e = 1'b0;

    // R2: asynchronous reset clears the held byte at once
    @(negedge clk); rst_n = 1'b0;
    #1; chk("R2 reset mid-run", 32'(mem_addr[7:0]), 32'(0));
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule